// File: doc/BRIEF.md
# Masked Prioritized Interrupt Controller

This block collects a set of interrupt request lines that arrive with no timing relation to the core clock. It brings each line into the clock domain, drops the lines that software has disabled, and presents the most urgent remaining request to the core as a single interrupt line. When the core accepts that interrupt, the controller records which source won and what address the core should branch to. It also marks that source as being serviced.

A source that is in service is held off, as is every source ranked below it, until software issues a return pulse. A source ranked above the one in service can still interrupt, so handlers can nest. The branch address is either one shared entry point, where software reads the source identifier to find the cause, or a separate vectored entry for each source. An input selects between the two. The controller does not save processor state.

Top module: `irq_rank_ctrl`

## Requirements
- R1: A change on a request input reaches the masking and ranking logic only after SYNC_STAGES rising clock edges. With the default of two stages, `irq_o` rises at the second edge after the request is first sampled high.
- R2: After reset, every mask bit is 0, so all sources are ignored. No source is in service, and `irq_o`, `id_o` and `addr_o` read 0.
- R3: A rising edge with `mask_wr_i` high loads `mask_wdata_i` into the mask. Mask bit i set to 1 enables source i. A source whose bit is 0 never raises `irq_o` and cannot win.
- R4: Source index 0 has the highest priority and index NUM_SRC-1 the lowest. Of the eligible requests, the lowest index wins, and that index is what `id_o` reports.
- R5: An interrupt is taken only at a rising edge where `ack_i` and `irq_o` are both high. At that edge the winner's index goes into `id_o`, its address goes into `addr_o`, and the source is marked in service. If `ack_i` is high while `irq_o` is low, nothing changes.
- R6: A source that is in service does not raise `irq_o`, and neither does any source ranked below it. A pending source ranked above every source in service does raise `irq_o`.
- R7: If `vec_mode_i` is 1 when an interrupt is taken, `addr_o` becomes VEC_BASE + (index << 4). If it is 0, `addr_o` becomes COMMON_ADDR.
- R8: A rising edge with `ret_i` high ends service for the highest-ranked source that is in service. That source can then interrupt again.
- R9: If an interrupt is taken at the same edge as a return, both take effect. The new winner is marked in service, and the source that was highest-ranked in service just before that edge is released.
- R10: Between two taken interrupts, `id_o` and `addr_o` hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_async_i | input | NUM_SRC | Raw interrupt requests, one per source, asynchronous |
| mask_wr_i | input | 1 | Load strobe for the enable mask |
| mask_wdata_i | input | NUM_SRC | New enable mask, 1 = enabled |
| vec_mode_i | input | 1 | 1 = per-source vectored address, 0 = shared address |
| ack_i | input | 1 | Core accepts the presented interrupt |
| ret_i | input | 1 | Return from the current handler |
| irq_o | output | 1 | Interrupt request to the core |
| id_o | output | IDX_W | Index of the most recently taken source |
| addr_o | output | ADDR_W | Branch address of the most recently taken source |

## Verification
The case most likely to fail is a take and a return landing on the same clock edge. That edge both sets and clears in-service bits, and the two must not disturb each other. The stimulus table provokes this with a low-ranked source in service and a higher-ranked source pending. It then pulses `ack_i` and `ret_i` together. After that edge the bench expects the new identifier and its vectored address, and it expects `irq_o` to stay low, because the new source now blocks everything below it. The next return must then leave no source in service, which shows that the lower source was released at the shared edge.

// File: rtl/irq_rank_pkg.sv
package irq_rank_pkg;
   // Branch address style chosen when an interrupt is taken
   typedef enum logic {
      ADDR_COMMON = 1'b0,
      ADDR_VECTOR = 1'b1
   } addr_mode_e;

   localparam int unsigned DEF_NUM_SRC     = 8;
   localparam int unsigned DEF_SYNC_STAGES = 2;
   localparam int unsigned DEF_ADDR_W      = 32;
   localparam int unsigned DEF_VEC_SHIFT   = 4;
endpackage

// File: rtl/irq_sync.sv
// Per-line synchronizer chain: STAGES flops per request bit (R1)
module irq_sync #(
   parameter int unsigned W      = 8,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic [W-1:0] async_i,
   output logic [W-1:0] sync_o
);
   logic [W-1:0] stg_q [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) stg_q[s] <= '0;
            else         stg_q[s] <= async_i;
         end
      end else begin : g_next
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) stg_q[s] <= '0;
            else         stg_q[s] <= stg_q[s-1];
         end
      end
   end

   assign sync_o = stg_q[STAGES-1];
endmodule

// File: rtl/irq_prio.sv
// Fixed-priority ranking with in-service blocking (R4, R6)
module irq_prio #(
   parameter int unsigned W     = 8,
   parameter int unsigned IDX_W = 3
) (
   input  logic [W-1:0]     pending_i,
   input  logic [W-1:0]     in_svc_i,
   output logic             valid_o,
   output logic [IDX_W-1:0] idx_o
);
   // allowed[i]: no source at index <= i is in service
   logic [W-1:0] allowed;
   logic [W-1:0] eligible;

   for (genvar i = 0; i < W; i++) begin : g_allow
      if (i == 0) begin : g_lsb
         assign allowed[i] = ~in_svc_i[i];
      end else begin : g_rest
         assign allowed[i] = allowed[i-1] & ~in_svc_i[i];
      end
   end

   assign eligible = pending_i & allowed;
   assign valid_o  = |eligible;

   always_comb begin
      idx_o = '0;
      for (int i = int'(W) - 1; i >= 0; i--) begin
         if (eligible[i]) idx_o = IDX_W'(i);
      end
   end
endmodule

// File: rtl/irq_svc.sv
// In-service tracking plus identifier / address capture (R5, R7, R8, R9, R10)
module irq_svc
   import irq_rank_pkg::*;
#(
   parameter int unsigned       W           = 8,
   parameter int unsigned       IDX_W       = 3,
   parameter int unsigned       ADDR_W      = 32,
   parameter int unsigned       VEC_SHIFT   = 4,
   parameter logic [ADDR_W-1:0] COMMON_ADDR = '0,
   parameter logic [ADDR_W-1:0] VEC_BASE    = '0
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              take_i,
   input  logic [IDX_W-1:0]  win_i,
   input  addr_mode_e        mode_i,
   input  logic              ret_i,
   output logic [W-1:0]      in_svc_o,
   output logic [IDX_W-1:0]  id_o,
   output logic [ADDR_W-1:0] addr_o
);
   logic [W-1:0]      svc_q, set_v, clr_v;
   logic [IDX_W-1:0]  id_q;
   logic [ADDR_W-1:0] addr_q, tgt_addr;

   // the lowest set bit of the in-service vector is the one being returned from
   assign clr_v = ret_i  ? (svc_q & (~svc_q + W'(1))) : '0;
   assign set_v = take_i ? (W'(1) << win_i)           : '0;

   always_comb begin
      if (mode_i == ADDR_VECTOR) tgt_addr = VEC_BASE + (ADDR_W'(win_i) << VEC_SHIFT);
      else                       tgt_addr = COMMON_ADDR;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         svc_q  <= '0;
         id_q   <= '0;
         addr_q <= '0;
      end else begin
         svc_q <= (svc_q & ~clr_v) | set_v;
         if (take_i) begin
            id_q   <= win_i;
            addr_q <= tgt_addr;
         end
      end
   end

   assign in_svc_o = svc_q;
   assign id_o     = id_q;
   assign addr_o   = addr_q;
endmodule

// File: rtl/irq_rank_ctrl.sv
module irq_rank_ctrl
   import irq_rank_pkg::*;
#(
   parameter int unsigned       NUM_SRC     = DEF_NUM_SRC,
   parameter int unsigned       SYNC_STAGES = DEF_SYNC_STAGES,
   parameter int unsigned       ADDR_W      = DEF_ADDR_W,
   parameter int unsigned       VEC_SHIFT   = DEF_VEC_SHIFT,
   parameter logic [ADDR_W-1:0] COMMON_ADDR = ADDR_W'(32'h0000_0800),
   parameter logic [ADDR_W-1:0] VEC_BASE    = ADDR_W'(32'h0000_1000),
   localparam int unsigned      IDX_W       = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic [NUM_SRC-1:0] req_async_i,
   input  logic              mask_wr_i,
   input  logic [NUM_SRC-1:0] mask_wdata_i,
   input  logic              vec_mode_i,
   input  logic              ack_i,
   input  logic              ret_i,
   output logic              irq_o,
   output logic [IDX_W-1:0]  id_o,
   output logic [ADDR_W-1:0] addr_o
);
   initial begin
      if (NUM_SRC < 2)                  $fatal(1, "NUM_SRC must be at least 2");
      if (SYNC_STAGES < 2)              $fatal(1, "SYNC_STAGES must be at least 2");
      if (IDX_W + VEC_SHIFT > ADDR_W)   $fatal(1, "vector offset exceeds ADDR_W");
   end

   logic [NUM_SRC-1:0] req_sync, mask_q, isr_q, pending;
   logic               win_valid, take;
   logic [IDX_W-1:0]   win_idx;
   addr_mode_e         mode;

   irq_sync #(.W(NUM_SRC), .STAGES(SYNC_STAGES)) u_sync (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .async_i (req_async_i),
      .sync_o  (req_sync)
   );

   // enable mask, 1 = source enabled (R3); reset clears it (R2)
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        mask_q <= '0;
      else if (mask_wr_i) mask_q <= mask_wdata_i;
   end

   assign pending = req_sync & mask_q & ~isr_q;

   irq_prio #(.W(NUM_SRC), .IDX_W(IDX_W)) u_prio (
      .pending_i (pending),
      .in_svc_i  (isr_q),
      .valid_o   (win_valid),
      .idx_o     (win_idx)
   );

   assign take = ack_i & win_valid;
   assign mode = addr_mode_e'(vec_mode_i);

   irq_svc #(
      .W(NUM_SRC), .IDX_W(IDX_W), .ADDR_W(ADDR_W), .VEC_SHIFT(VEC_SHIFT),
      .COMMON_ADDR(COMMON_ADDR), .VEC_BASE(VEC_BASE)
   ) u_svc (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .take_i   (take),
      .win_i    (win_idx),
      .mode_i   (mode),
      .ret_i    (ret_i),
      .in_svc_o (isr_q),
      .id_o     (id_o),
      .addr_o   (addr_o)
   );

   assign irq_o = win_valid;
endmodule

// File: rtl/irq_rank_chk.sv
module irq_rank_chk #(
   parameter int unsigned       NUM_SRC     = 8,
   parameter int unsigned       ADDR_W      = 32,
   parameter int unsigned       VEC_SHIFT   = 4,
   parameter logic [ADDR_W-1:0] COMMON_ADDR = '0,
   parameter logic [ADDR_W-1:0] VEC_BASE    = '0,
   parameter int unsigned       IDX_W       = 3
) (
   input logic               clk_i,
   input logic               rst_ni,
   input logic               ack_i,
   input logic               ret_i,
   input logic               vec_mode_i,
   input logic               irq_o,
   input logic [IDX_W-1:0]   id_o,
   input logic [ADDR_W-1:0]  addr_o,
   input logic [NUM_SRC-1:0] sync_req,
   input logic [NUM_SRC-1:0] mask,
   input logic [NUM_SRC-1:0] isr
);
   a_r3_masked_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_o |-> |(sync_req & mask));

   a_r5_take_marks_svc: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ack_i && irq_o) |=> isr[id_o]);

   a_r7_vector_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ack_i && irq_o && vec_mode_i) |=> addr_o == VEC_BASE + (ADDR_W'(id_o) << VEC_SHIFT));

   a_r7_common_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ack_i && irq_o && !vec_mode_i) |=> addr_o == COMMON_ADDR);

   a_r10_hold_outputs: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(ack_i && irq_o) |=> ($stable(id_o) && $stable(addr_o)));

   a_r8_ret_drops_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ret_i && (|isr) && !(ack_i && irq_o)) |=> $countones(isr) == $past($countones(isr)) - 1);
endmodule

bind irq_rank_ctrl irq_rank_chk #(
   .NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W), .VEC_SHIFT(VEC_SHIFT),
   .COMMON_ADDR(COMMON_ADDR), .VEC_BASE(VEC_BASE), .IDX_W(IDX_W)
) u_chk (
   .clk_i      (clk_i),
   .rst_ni     (rst_ni),
   .ack_i      (ack_i),
   .ret_i      (ret_i),
   .vec_mode_i (vec_mode_i),
   .irq_o      (irq_o),
   .id_o       (id_o),
   .addr_o     (addr_o),
   .sync_req   (req_sync),
   .mask       (mask_q),
   .isr        (isr_q)
);

// File: tb/sim_irq_rank_ctrl.sv
module sim_irq_rank_ctrl;
   localparam int unsigned N    = 8;
   localparam int unsigned IW   = 3;
   localparam int unsigned AW   = 32;
   localparam int unsigned NVEC = 12;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [N-1:0]  req = '0;
   logic          mwr = 1'b0;
   logic [N-1:0]  mdat = '0;
   logic          vmode = 1'b0;
   logic          ack = 1'b0;
   logic          ret = 1'b0;
   logic          irq;
   logic [IW-1:0] id;
   logic [AW-1:0] addr;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;   // 125 MHz

   irq_rank_ctrl u0 (
      .clk_i(clk), .rst_ni(rst_n), .req_async_i(req), .mask_wr_i(mwr),
      .mask_wdata_i(mdat), .vec_mode_i(vmode), .ack_i(ack), .ret_i(ret),
      .irq_o(irq), .id_o(id), .addr_o(addr)
   );

   typedef struct packed {
      logic [N-1:0]  req;
      logic [N-1:0]  mask;
      logic          mode;
      logic          ack;
      logic          ret;
      logic          pre_irq;
      logic [IW-1:0] id;
      logic [AW-1:0] addr;
      logic          post_irq;
   } vec_t;

   // shared address 0x800, vectored base 0x1000, vector = base + id*16
   localparam vec_t TBL [NVEC] = '{
      '{8'h00, 8'hFF, 1'b1, 1'b1, 1'b0, 1'b0, 3'd0, 32'h0000_0000, 1'b0}, // R5 ack, nothing pending
      '{8'h30, 8'hFF, 1'b1, 1'b1, 1'b0, 1'b1, 3'd4, 32'h0000_1040, 1'b0}, // R4 R7 R6
      '{8'h32, 8'hFD, 1'b1, 1'b0, 1'b0, 1'b0, 3'd4, 32'h0000_1040, 1'b0}, // R3 R10
      '{8'h32, 8'hFF, 1'b0, 1'b1, 1'b0, 1'b1, 3'd1, 32'h0000_0800, 1'b0}, // R6 nest, R7 shared
      '{8'h32, 8'hFF, 1'b0, 1'b0, 1'b1, 1'b0, 3'd1, 32'h0000_0800, 1'b1}, // R8
      '{8'h32, 8'hFF, 1'b1, 1'b1, 1'b1, 1'b1, 3'd1, 32'h0000_1010, 1'b0}, // R9 take + return
      '{8'h00, 8'hFF, 1'b1, 1'b0, 1'b1, 1'b0, 3'd1, 32'h0000_1010, 1'b0}, // R9 source 4 gone
      '{8'h81, 8'hFF, 1'b1, 1'b1, 1'b0, 1'b1, 3'd0, 32'h0000_1000, 1'b0}, // R4 index 0
      '{8'h80, 8'hFF, 1'b1, 1'b0, 1'b1, 1'b0, 3'd0, 32'h0000_1000, 1'b1}, // R6 R8
      '{8'h80, 8'h7F, 1'b1, 1'b1, 1'b0, 1'b0, 3'd0, 32'h0000_1000, 1'b0}, // R3 R5
      '{8'h80, 8'hFF, 1'b1, 1'b1, 1'b0, 1'b1, 3'd7, 32'h0000_1070, 1'b0}, // R4 lowest rank
      '{8'h00, 8'hFF, 1'b1, 1'b0, 1'b1, 1'b0, 3'd7, 32'h0000_1070, 1'b0}  // R8
   };

   task automatic check(input string tag, input logic [AW-1:0] act, input logic [AW-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: got %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic cycles(input int n);
      for (int k = 0; k < n; k++) @(negedge clk);
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin : main
      cycles(3);
      // R2 reset state
      check("R2 irq", AW'(irq), 0);
      check("R2 id", AW'(id), 0);
      check("R2 addr", addr, 0);
      rst_n = 1'b1;
      req = 8'hFF;
      cycles(4);
      check("R2 mask cleared, irq", AW'(irq), 0);
      req = 8'h00;
      cycles(3);

      for (int v = 0; v < int'(NVEC); v++) begin
         req   = TBL[v].req;
         mdat  = TBL[v].mask;
         vmode = TBL[v].mode;
         mwr   = 1'b1;
         cycles(1);
         mwr   = 1'b0;
         cycles(3);
         check($sformatf("R6 vec%0d pre irq", v), AW'(irq), AW'(TBL[v].pre_irq));
         ack = TBL[v].ack;
         ret = TBL[v].ret;
         cycles(1);
         ack = 1'b0;
         ret = 1'b0;
         check($sformatf("R4 vec%0d id", v), AW'(id), AW'(TBL[v].id));
         check($sformatf("R7 vec%0d addr", v), addr, TBL[v].addr);
         check($sformatf("R8 vec%0d post irq", v), AW'(irq), AW'(TBL[v].post_irq));
      end

      // R1 synchronizer latency: nothing in service, mask all enabled
      req = 8'h04;
      @(posedge clk); @(negedge clk);
      check("R1 after one edge", AW'(irq), 0);
      @(posedge clk); @(negedge clk);
      check("R1 after two edges", AW'(irq), 1);
      vmode = 1'b1;
      ack = 1'b1;
      cycles(1);
      ack = 1'b0;
      check("R5 id after take", AW'(id), 2);
      check("R7 addr after take", addr, 32'h0000_1020);
      req = 8'h00;
      ret = 1'b1;
      cycles(1);
      ret = 1'b0;
      cycles(3);
      check("R10 id held", AW'(id), 2);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule